// File: doc/BRIEF.md
# Asynchronous Write-Cycle Bus Master

This block runs one write transfer on an asynchronous 32-bit bus. It accepts a request that carries an address, write data, a transfer size, an operand-start flag and a no-cache flag. It then steps through a fixed sequence of bus states. Each state lasts one period of `clk`, and `clk` runs at twice the bus clock, so each state is one half of a bus clock. The block drives the cycle-start strobes, the read/write line, the address strobe, the data buffer enable, the data strobe and the write data. It waits for the slave's two-bit size acknowledge, and it reports the end of the cycle with a one-state `done` pulse.

The acknowledge lines are active low. They pass through a two-flop synchronizer before the state machine reads them. The first sample is taken in the third state, and each wait state makes one more sample. A wait lasts two states, which is one full bus clock. If no acknowledge arrives within a set number of waits, the block ends the cycle and flags `timeout_err`.

The block drives the data bus through an output-enable pin (`bus_doe`) plus a value (`bus_dout`). The tri-state pad is outside the block. Narrow operands are copied onto every byte lane, so the slave finds its bytes on whichever lanes it is wired to.

Top module: `wrbus_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, the outputs are idle: `cyc_start_n`, `opnd_start_n`, `addr_strb_n`, `data_strb_n` and `buf_en_n` are all 1, `rd_wr` is 1, and `bus_doe`, `done` and `timeout_err` are all 0. Reset is asynchronous, so a reset during a cycle returns the outputs to idle at once.
- R2: `req_valid` is sampled only when the block is idle. In the state that starts at the accepting edge (state 0), `cyc_start_n` is 0, `opnd_start_n` is 0 only if `req_opnd` was 1, and `rd_wr` is 0. In the same state `bus_addr`, `bus_size` and `no_cache` show the request's values. A request raised while a cycle runs is ignored: the address does not change and no extra cycle follows.
- R3: In state 1, `addr_strb_n` and `buf_en_n` go to 0, and both cycle-start strobes return to 1. The address holds steady while `addr_strb_n` is 0.
- R4: From state 2 through the final state, `bus_doe` is 1 and `bus_dout` carries the write data.
- R5: In state 3, `data_strb_n` goes to 0.
- R6: The acknowledge counts when either bit of `size_ack_n` is 0 after two synchronizer flops. It is sampled in state 2 and in the first half of each wait.
- R7: If no acknowledge was recognized when state 3 ends, the block adds waits of two states each and keeps both strobes asserted. With N waits, state 4 begins 4+2N edges after acceptance.
- R8: No output changes between state 3 (or the last wait) and state 4. In state 5, `addr_strb_n`, `data_strb_n` and `buf_en_n` go to 1, `done` is 1 for that state only, and the data is still driven. One state later `bus_doe` is 0 and `rd_wr` is 1.
- R9: If WAIT_LIMIT waits pass with no acknowledge, the block enters state 5 at edge 4+2·WAIT_LIMIT with `timeout_err` = 1 together with `done`. An acknowledge recognized in the last allowed wait completes the cycle normally.
- R10: Data lanes follow the `req_size` encoding:
  - 01 is a byte: bits 7:0 are copied to all four lanes.
  - 10 is a word: bits 15:0 are copied to both halves.
  - 00 (long) and 11 (three bytes) pass the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, taken only when idle |
| req_addr | input | 32 | Request address |
| req_data | input | 32 | Request write data (operand in the low bits) |
| req_size | input | 2 | Transfer size code |
| req_opnd | input | 1 | Cycle is the first of an operand |
| req_nocache | input | 1 | No-cache attribute for the cycle |
| size_ack_n | input | 2 | Asynchronous size acknowledge from the slave, active low |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Bus size code |
| rd_wr | output | 1 | Read/write line, 0 during the write cycle |
| no_cache | output | 1 | Cache-inhibit output |
| cyc_start_n | output | 1 | Cycle-start strobe |
| opnd_start_n | output | 1 | Operand-start strobe |
| addr_strb_n | output | 1 | Address strobe |
| data_strb_n | output | 1 | Data strobe |
| buf_en_n | output | 1 | Data buffer enable |
| bus_dout | output | 32 | Write data value |
| bus_doe | output | 1 | Data bus output enable (0 means high impedance) |
| done | output | 1 | One-state pulse in the final state |
| timeout_err | output | 1 | Set together with done when the cycle timed out |

## Verification
Every output register loads at the same edge that enters its state. So if a request is taken at edge k, the outputs for state m appear after edge k+m, and each wait pushes the closing states later by two edges. The acknowledge reaches the state machine two edges after the input changes. The bench therefore drives the raw acknowledge at the falling edge after edge k+2N, which gives exactly N waits. The bench works out which state is due at every edge from that offset and samples all outputs at the following falling edge. It does this for every cycle from acceptance until the block is idle again, so each strobe edge is checked in its exact state.

// File: rtl/wrbus_pkg.sv
package wrbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_W1, ST_W2, ST_S4, ST_S5
  } wr_state_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_TRI  = 2'b11;

  typedef struct packed {
    logic cyc_n;
    logic opnd_n;
    logic as_n;
    logic ds_n;
    logic buf_n;
    logic rw;
    logic oe;
    logic done;
  } strobe_t;

  localparam strobe_t STRB_IDLE = '{cyc_n: 1'b1, opnd_n: 1'b1, as_n: 1'b1,
                                    ds_n: 1'b1, buf_n: 1'b1, rw: 1'b1,
                                    oe: 1'b0, done: 1'b0};

  // Output levels that belong to each bus state
  function automatic strobe_t strobe_decode(wr_state_e s, logic opnd);
    strobe_t o;
    o = STRB_IDLE;
    case (s)
      ST_S0: begin
        o.cyc_n  = 1'b0;
        o.opnd_n = ~opnd;
        o.rw     = 1'b0;
      end
      ST_S1: begin
        o.as_n  = 1'b0;
        o.buf_n = 1'b0;
        o.rw    = 1'b0;
      end
      ST_S2: begin
        o.as_n  = 1'b0;
        o.buf_n = 1'b0;
        o.rw    = 1'b0;
        o.oe    = 1'b1;
      end
      ST_S3, ST_W1, ST_W2, ST_S4: begin
        o.as_n  = 1'b0;
        o.buf_n = 1'b0;
        o.ds_n  = 1'b0;
        o.rw    = 1'b0;
        o.oe    = 1'b1;
      end
      ST_S5: begin
        o.rw   = 1'b0;
        o.oe   = 1'b1;
        o.done = 1'b1;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/wrbus_ack_sync.sv
module wrbus_ack_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];

  // R6: the output follows the input exactly STAGES edges later (two-stage case)
  a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (STAGES == 2 && $past(rst_n, 2)) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/wrbus_lane_mux.sv
module wrbus_lane_mux
  import wrbus_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int LANES = DW / 8;
  localparam int HALVES = LANES / 2;

  // R10: narrow operands are copied across the lanes
  always_comb begin
    case (size)
      SZ_BYTE: dout = {LANES{din[7:0]}};
      SZ_WORD: dout = {HALVES{din[15:0]}};
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/wrbus_wait_timer.sv
module wrbus_wait_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign at_limit = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (inc && !at_limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: the wait count never runs past the limit
  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/wrbus_master.sv
module wrbus_master
  import wrbus_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WAIT_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_size,
  input  logic          req_opnd,
  input  logic          req_nocache,
  input  logic [1:0]    size_ack_n,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          rd_wr,
  output logic          no_cache,
  output logic          cyc_start_n,
  output logic          opnd_start_n,
  output logic          addr_strb_n,
  output logic          data_strb_n,
  output logic          buf_en_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          done,
  output logic          timeout_err
);

  wr_state_e     state_q, state_d;
  logic          load;
  logic [1:0]    ack_sync_n;
  logic          ack_any;
  logic          ack_hit_q;
  logic          abort_d;
  logic          wt_clear, wt_inc, wt_at_limit;
  logic          opnd_q, opnd_nx;
  logic [DW-1:0] lane_data, data_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          nc_q;
  strobe_t       strb_q, strb_d;
  logic          err_q;

  // ---------------- submodules ----------------
  wrbus_ack_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(1'b1)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (size_ack_n),
    .dout (ack_sync_n)
  );

  wrbus_lane_mux #(.DW(DW)) u_lane_mux (
    .size(req_size),
    .din (req_data),
    .dout(lane_data)
  );

  wrbus_wait_timer #(.LIMIT(WAIT_LIMIT)) u_wait_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wt_clear),
    .inc     (wt_inc),
    .at_limit(wt_at_limit)
  );

  assign ack_any = |(~ack_sync_n);
  assign load    = (state_q == ST_IDLE) && req_valid;
  assign opnd_nx = load ? req_opnd : opnd_q;

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ack_hit_q ? ST_S4 : ST_W1;
      ST_W1:   state_d = ST_W2;
      ST_W2: begin
        if (ack_hit_q) begin
          state_d = ST_S4;
        end else if (wt_at_limit) begin
          state_d = ST_S5;
          abort_d = 1'b1;
        end else begin
          state_d = ST_W1;
        end
      end
      ST_S4:   state_d = ST_S5;
      ST_S5:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign wt_clear = (state_q == ST_S0);
  assign wt_inc   = (state_d == ST_W1);
  assign strb_d   = strobe_decode(state_d, opnd_nx);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= STRB_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
      err_q   <= abort_d;
    end
  end

  // Acknowledge is sampled in state 2 and the first half of each wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_hit_q <= 1'b0;
    end else if (state_q == ST_S0) begin
      ack_hit_q <= 1'b0;
    end else if ((state_q == ST_S2 || state_q == ST_W1) && ack_any) begin
      ack_hit_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      nc_q   <= 1'b0;
      opnd_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= req_addr;
      size_q <= req_size;
      nc_q   <= req_nocache;
      opnd_q <= req_opnd;
      data_q <= lane_data;
    end
  end

  // ---------------- outputs ----------------
  assign bus_addr     = addr_q;
  assign bus_size     = size_q;
  assign no_cache     = nc_q;
  assign rd_wr        = strb_q.rw;
  assign cyc_start_n  = strb_q.cyc_n;
  assign opnd_start_n = strb_q.opnd_n;
  assign addr_strb_n  = strb_q.as_n;
  assign data_strb_n  = strb_q.ds_n;
  assign buf_en_n     = strb_q.buf_n;
  assign bus_doe      = strb_q.oe;
  assign bus_dout     = data_q;
  assign done         = strb_q.done;
  assign timeout_err  = err_q;

  // ---------------- assertions ----------------
  // R2: cycle-start strobe lasts a single state
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_start_n) |=> cyc_start_n);

  // R3: address is steady while the address strobe is asserted
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strb_n && !$past(addr_strb_n)) |-> $stable(bus_addr));

  // R5: data strobe only while data is driven under an asserted address strobe
  a_r5_ds_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    !data_strb_n |-> (bus_doe && !addr_strb_n));

  // R7: strobes stay asserted through wait states
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_W1 || state_q == ST_W2) |-> (!data_strb_n && !addr_strb_n));

  // R8: done is a one-state pulse with strobes negated
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_negated: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (addr_strb_n && data_strb_n && buf_en_n && bus_doe));

  // R9: a timeout is always reported with done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

endmodule

// File: tb/test_wrbus_master.sv
module test_wrbus_master;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [1:0]    req_size;
  logic          req_opnd;
  logic          req_nocache;
  logic [1:0]    size_ack_n;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          rd_wr, no_cache, cyc_start_n, opnd_start_n;
  logic          addr_strb_n, data_strb_n, buf_en_n;
  logic [DW-1:0] bus_dout;
  logic          bus_doe, done, timeout_err;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  wrbus_master #(.AW(AW), .DW(DW), .WAIT_LIMIT(LIM)) i_wrbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_size(req_size), .req_opnd(req_opnd),
    .req_nocache(req_nocache), .size_ack_n(size_ack_n), .bus_addr(bus_addr),
    .bus_size(bus_size), .rd_wr(rd_wr), .no_cache(no_cache),
    .cyc_start_n(cyc_start_n), .opnd_start_n(opnd_start_n),
    .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n), .buf_en_n(buf_en_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .done(done), .timeout_err(timeout_err)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        opnd;
    logic        nc;
    logic [3:0]  nwait;
    logic [1:0]  ack;
    logic [31:0] exp;
  } vec_t;

  // Stimulus and expected lane data (R10 encoding: 01 byte, 10 word, 00/11 as-is)
  localparam vec_t VECS [5] = '{
    '{32'h0000_1000, 32'hA1B2_C3D4, 2'b00, 1'b1, 1'b0, 4'd0, 2'b00, 32'hA1B2_C3D4},
    '{32'h0000_2003, 32'h0000_005A, 2'b01, 1'b0, 1'b1, 4'd1, 2'b10, 32'h5A5A_5A5A},
    '{32'h0000_3002, 32'h1234_BEEF, 2'b10, 1'b1, 1'b0, 4'd3, 2'b01, 32'hBEEF_BEEF},
    '{32'h0000_4001, 32'h00CA_FE01, 2'b11, 1'b0, 1'b1, 4'd2, 2'b00, 32'h00CA_FE01},
    '{32'hFFFF_FFFC, 32'hDEAD_0000, 2'b00, 1'b1, 1'b1, 4'd8, 2'b10, 32'hDEAD_0000}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {cyc, opnd, as, ds, buf, rw, doe, done, err}
  function automatic logic [8:0] outs_now();
    return {cyc_start_n, opnd_start_n, addr_strb_n, data_strb_n, buf_en_n,
            rd_wr, bus_doe, done, timeout_err};
  endfunction

  localparam logic [8:0] IDLE_OUTS = 9'b1_1111_1000;

  // Phase: 0..2 first states, 3 data strobe / waits, 4 closing, 5 final, 6 idle
  function automatic int phase_of(int t, int nw, bit to);
    int last;
    if (t <= 3) return t;
    last = to ? 4 + 2*LIM : 4 + 2*nw;
    if (t < last) return 3;
    if (to) return (t == last) ? 5 : 6;
    if (t == last) return 4;
    if (t == last + 1) return 5;
    return 6;
  endfunction

  function automatic logic [8:0] exp_outs(int ph, bit opnd, bit to);
    logic [8:0] e;
    e = IDLE_OUTS;
    case (ph)
      0: begin e[8] = 1'b0; e[7] = ~opnd; e[3] = 1'b0; end
      1: begin e[6] = 1'b0; e[4] = 1'b0; e[3] = 1'b0; end
      2: begin e[6] = 1'b0; e[4] = 1'b0; e[3] = 1'b0; e[2] = 1'b1; end
      3, 4: begin e[6] = 1'b0; e[5] = 1'b0; e[4] = 1'b0; e[3] = 1'b0; e[2] = 1'b1; end
      5: begin e[3] = 1'b0; e[2] = 1'b1; e[1] = 1'b1; e[0] = to; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_of(int ph, bit to);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5,R6,R7";
      4: return "R6,R8";
      5: return to ? "R9" : "R8";
      default: return "R8";
    endcase
  endfunction

  // One full write cycle; inj raises a request mid-cycle that must be ignored
  task automatic run_cycle(input vec_t v, input bit to, input bit inj);
    int last;
    int ph;
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = v.addr;
    req_data    = v.data;
    req_size    = v.size;
    req_opnd    = v.opnd;
    req_nocache = v.nc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last = to ? 5 + 2*LIM : 6 + 2*int'(v.nwait);
    for (int t = 0; t <= last; t++) begin
      ph = phase_of(t, int'(v.nwait), to);
      check(outs_now() == exp_outs(ph, v.opnd, to), tag_of(ph, to),
            32'(outs_now()), 32'(exp_outs(ph, v.opnd, to)));
      check(bus_addr == v.addr, "R2,R3 addr", bus_addr, v.addr);
      if (ph == 0) begin
        check({bus_size, no_cache} == {v.size, v.nc}, "R2 size/nocache",
              32'({bus_size, no_cache}), 32'({v.size, v.nc}));
      end
      if (ph >= 2 && ph <= 5) begin
        check(bus_dout == v.exp, "R4,R10 data", bus_dout, v.exp);
      end
      if (!to && t == 2*int'(v.nwait)) size_ack_n = v.ack;
      if (inj && t == 2) begin
        req_valid = 1'b1;
        req_addr  = 32'h5555_0000;
      end
      if (inj && t == 3) req_valid = 1'b0;
      if (t < last) @(negedge clk);
    end
    size_ack_n = 2'b11;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_addr    = '0;
    req_data    = '0;
    req_size    = 2'b00;
    req_opnd    = 1'b0;
    req_nocache = 1'b0;
    size_ack_n  = 2'b11;

    // R1: idle during and after reset
    repeat (2) @(negedge clk);
    check(outs_now() == IDLE_OUTS, "R1 in reset", 32'(outs_now()), 32'(IDLE_OUTS));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(outs_now() == IDLE_OUTS, "R1 after reset", 32'(outs_now()), 32'(IDLE_OUTS));

    // Table walk: zero, one, two, three waits and the last allowed wait (R9)
    for (int i = 0; i < 5; i++) begin
      run_cycle(VECS[i], 1'b0, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: no acknowledge at all ends with the error flag
    run_cycle(VECS[0], 1'b1, 1'b0);
    repeat (2) @(negedge clk);

    // R2: request raised mid-cycle is ignored, and no extra cycle follows
    run_cycle(VECS[2], 1'b0, 1'b1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(outs_now() == IDLE_OUTS, "R2 no phantom cycle",
            32'(outs_now()), 32'(IDLE_OUTS));
    end

    // R1: reset in the middle of a cycle returns to idle at once
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h0000_7770;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(outs_now() == IDLE_OUTS, "R1 mid-cycle reset",
          32'(outs_now()), 32'(IDLE_OUTS));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cycle(VECS[1], 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule